// File: doc/BRIEF.md
# Reverse-Polish Expression Engine

This block is a small stack-organized processor that runs zero-address programs. Each instruction is one word holding a 4-bit opcode in its upper bits and a memory address in its lower bits. Two opcodes move data between a data memory and an internal operand stack: one loads a variable onto the stack and one stores the top entry back to memory. Four arithmetic opcodes take no operand. Each of them removes the top two stack entries and pushes one result in their place. A halt opcode ends the program.

A host first fills the program and data memories and then pulses `start`. The engine then fetches one instruction per clock, beginning at address zero with an empty stack. It stops when it reaches the halt opcode, which raises `done`. It also stops on any fault, which raises `done` together with `error`. Both memories are read combinationally. Data memory writes take effect on the clock edge at which `dmem_we` is high. Expressions written in reverse Polish order, such as `3 4 + 10 2 6 + * 8 + *`, evaluate directly.

Top module: `rpn_engine`

## Requirements
- R1: After reset, `done`, `error` and `dmem_we` are low, and the engine fetches nothing until `start`.
- R2: A `start` pulse while idle or stopped clears `done` and `error`, empties the stack and begins at instruction address 0. From then on, one instruction completes per clock, so a program of N instructions followed by a halt raises `done` N+1 cycles after the cycle that sampled `start`.
- R3: Opcode 4'h1 (load) reads data memory at the address held in bits [11:0] and places the value on top of the stack.
- R4: Opcode 4'h2 (store) writes the top entry to data memory at the address held in bits [11:0] and removes it. No other opcode writes data memory, so source variables are never modified.
- R5: Opcodes 4'h3 (add), 4'h4 (subtract) and 4'h5 (multiply) replace the two top entries with one result, modulo 2^16. The deeper entry is the left operand. Bits [11:0] of these instructions have no effect.
- R6: Opcode 4'h6 (divide) replaces the two top entries with the unsigned truncated quotient of the deeper entry divided by the top entry. A zero divisor raises `error` and `done`.
- R7: Opcode 4'h0 (halt) raises `done` with `error` low. `done` stays high until the next `start`, and no later instruction executes.
- R8: A load while the stack already holds 8 entries raises `error` and `done`. Exactly 8 entries are accepted.
- R9: A store on an empty stack, or an arithmetic opcode with fewer than two entries, raises `error` and `done` without writing memory.
- R10: Opcodes 4'h7 to 4'hF are illegal and raise `error` and `done`.
- R11: Once stopped, the engine asserts no further data memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program run when idle or stopped |
| imem_addr | output | 12 | Instruction address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 12 | Data memory address from the instruction field |
| dmem_rdata | input | 16 | Data memory contents at `dmem_addr` |
| dmem_wdata | output | 16 | Value to store (top of stack) |
| dmem_we | output | 1 | Data memory write enable |
| done | output | 1 | Program has stopped (halt or fault) |
| error | output | 1 | Program stopped on a fault |

## Verification
The stack depth counter and the slot contents are hidden. A wrong depth shows up at the ports as a spurious or missing `error`, no later than the next instruction that tests the stack bounds. A wrong slot value shows up as a wrong `dmem_wdata` at the next store that reaches that slot. A wrong program counter shows up as a wrong `imem_addr` and as `done` arriving on the wrong cycle, so the bench times each run from `start` to `done`. It also stores intermediate results mid-expression, so that a corrupted entry is caught close to the instruction that produced it.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  localparam logic [3:0] OPC_HALT = 4'h0;
  localparam logic [3:0] OPC_LOAD = 4'h1;
  localparam logic [3:0] OPC_STOR = 4'h2;
  localparam logic [3:0] OPC_ADD  = 4'h3;
  localparam logic [3:0] OPC_SUB  = 4'h4;
  localparam logic [3:0] OPC_MUL  = 4'h5;
  localparam logic [3:0] OPC_DIV  = 4'h6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } run_state_t;

  function automatic logic is_operator(input logic [3:0] op);
    return (op >= OPC_ADD) && (op <= OPC_DIV);
  endfunction

  function automatic logic is_illegal(input logic [3:0] op);
    return op > OPC_DIV;
  endfunction

endpackage

// File: rtl/rpn_alu.sv
module rpn_alu #(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] result,
  output logic          div_zero
);
  import rpn_pkg::*;

  function automatic logic [DW-1:0] reduce2(input logic [3:0] o,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    logic [2*DW-1:0] wide;
    wide = '0;
    unique case (o)
      OPC_ADD: wide = {{DW{1'b0}}, a + b};
      OPC_SUB: wide = {{DW{1'b0}}, a - b};
      OPC_MUL: wide = a * b;
      OPC_DIV: wide = (b == '0) ? '0 : {{DW{1'b0}}, a / b};
      default: wide = '0;
    endcase
    return wide[DW-1:0];
  endfunction

  assign result   = reduce2(op, lhs, rhs);
  assign div_zero = (op == OPC_DIV) && (rhs == '0);

endmodule

// File: rtl/rpn_stack.sv
module rpn_stack #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push_i,
  input  logic [DW-1:0]    push_val,
  input  logic             pop_i,
  input  logic             fold_i,
  input  logic [DW-1:0]    fold_val,
  output logic [DW-1:0]    top_o,
  output logic [DW-1:0]    next_o,
  output logic [CNT_W-1:0] depth
);
  localparam int SLOT_W = $clog2(DEPTH);

  logic [DW-1:0]    slots [DEPTH];
  logic [DEPTH-1:0] we_push;
  logic [DEPTH-1:0] we_fold;
  logic [SLOT_W-1:0] idx_top;
  logic [SLOT_W-1:0] idx_nxt;

  // per-slot write decode: a load fills slot[depth], a fold rewrites slot[depth-2]
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
    assign we_push[g] = push_i && (depth == CNT_W'(g));
    assign we_fold[g] = fold_i && (depth == CNT_W'(g + 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_push[i])      slots[i] <= push_val;
        else if (we_fold[i]) slots[i] <= fold_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                depth <= '0;
    else if (clear)            depth <= '0;
    else if (push_i)           depth <= depth + CNT_W'(1);
    else if (pop_i || fold_i)  depth <= depth - CNT_W'(1);
  end

  assign idx_top = SLOT_W'(depth - CNT_W'(1));
  assign idx_nxt = SLOT_W'(depth - CNT_W'(2));
  assign top_o   = (depth == '0)        ? '0 : slots[idx_top];
  assign next_o  = (depth < CNT_W'(2))  ? '0 : slots[idx_nxt];

endmodule

// File: rtl/rpn_seq.sv
module rpn_seq #(
  parameter int AW    = 12,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       opcode,
  input  logic [CNT_W-1:0] depth,
  input  logic             div_zero,
  output logic [AW-1:0]    pc,
  output logic             running,
  output logic             done,
  output logic             error,
  output logic             ev_push,
  output logic             ev_pop,
  output logic             ev_fold,
  output logic             ev_fault,
  output logic             ev_halt,
  output logic             clear
);
  import rpn_pkg::*;

  run_state_t state;
  logic is_full, is_empty, has_pair;
  logic op_load, op_stor, op_arith;

  assign is_full  = depth == CNT_W'(DEPTH);
  assign is_empty = depth == '0;
  assign has_pair = depth >= CNT_W'(2);

  assign op_load  = opcode == OPC_LOAD;
  assign op_stor  = opcode == OPC_STOR;
  assign op_arith = is_operator(opcode);

  assign running  = state == ST_RUN;
  assign clear    = start && !running;

  assign ev_push  = running && op_load && !is_full;
  assign ev_pop   = running && op_stor && !is_empty;
  assign ev_fold  = running && op_arith && has_pair && !div_zero;
  assign ev_halt  = running && (opcode == OPC_HALT);
  assign ev_fault = running && ((op_load && is_full) ||
                                (op_stor && is_empty) ||
                                (op_arith && !has_pair) ||
                                (op_arith && has_pair && div_zero) ||
                                is_illegal(opcode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else if (clear) begin
      state <= ST_RUN;
      pc    <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else if (running) begin
      if (ev_fault) begin
        state <= ST_STOP;
        done  <= 1'b1;
        error <= 1'b1;
      end else if (ev_halt) begin
        state <= ST_STOP;
        done  <= 1'b1;
      end else begin
        pc <= pc + AW'(1);
      end
    end
  end

endmodule

// File: rtl/rpn_engine.sv
module rpn_engine #(
  parameter int AW     = 12,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int INSN_W = AW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [AW-1:0]     imem_addr,
  input  logic [INSN_W-1:0] imem_data,
  output logic [AW-1:0]     dmem_addr,
  input  logic [DW-1:0]     dmem_rdata,
  output logic [DW-1:0]     dmem_wdata,
  output logic              dmem_we,
  output logic              done,
  output logic              error
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [3:0]       opcode;
  logic [CNT_W-1:0] depth;
  logic [DW-1:0]    top_val, next_val, alu_res;
  logic             div_zero, running, clear;
  logic             ev_push, ev_pop, ev_fold, ev_fault, ev_halt;

  assign opcode    = imem_data[INSN_W-1 -: 4];
  assign dmem_addr = imem_data[AW-1:0];

  rpn_seq #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .opcode   (opcode),
    .depth    (depth),
    .div_zero (div_zero),
    .pc       (imem_addr),
    .running  (running),
    .done     (done),
    .error    (error),
    .ev_push  (ev_push),
    .ev_pop   (ev_pop),
    .ev_fold  (ev_fold),
    .ev_fault (ev_fault),
    .ev_halt  (ev_halt),
    .clear    (clear)
  );

  rpn_stack #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .push_i   (ev_push),
    .push_val (dmem_rdata),
    .pop_i    (ev_pop),
    .fold_i   (ev_fold),
    .fold_val (alu_res),
    .top_o    (top_val),
    .next_o   (next_val),
    .depth    (depth)
  );

  rpn_alu #(.DW(DW)) u_alu (
    .op       (opcode),
    .lhs      (next_val),
    .rhs      (top_val),
    .result   (alu_res),
    .div_zero (div_zero)
  );

  assign dmem_wdata = top_val;
  assign dmem_we    = ev_pop;

endmodule

// File: rtl/rpn_engine_chk.sv
module rpn_engine_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [3:0]       opcode,
  input logic             dmem_we,
  input logic             done,
  input logic             error,
  input logic             running,
  input logic             ev_push,
  input logic             ev_pop,
  input logic             ev_fold,
  input logic [CNT_W-1:0] depth
);
  import rpn_pkg::*;

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> (!done && !error));

  p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> depth == $past(depth) + CNT_W'(1));

  p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> depth == $past(depth) - CNT_W'(1));

  p_write_only_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> opcode == OPC_STOR);

  p_fold_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fold |=> depth == $past(depth) - CNT_W'(1));

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  p_error_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  p_quiet_when_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !dmem_we);

endmodule

bind rpn_engine rpn_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .opcode  (opcode),
  .dmem_we (dmem_we),
  .done    (done),
  .error   (error),
  .running (running),
  .ev_push (ev_push),
  .ev_pop  (ev_pop),
  .ev_fold (ev_fold),
  .depth   (depth)
);

// File: tb/test_rpn_engine.sv
`timescale 1ns/1ps
module test_rpn_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] imem_addr, dmem_addr;
  logic [15:0] imem_data, dmem_rdata, dmem_wdata;
  logic        dmem_we, done, error;

  logic [15:0] imem [64];
  logic [15:0] dmem [64];

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

  rpn_engine i_rpn_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_rdata (dmem_rdata),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .done       (done),
    .error      (error)
  );

  // opcode, a, b, expected, error
  localparam logic [52:0] VEC [9] = '{
    {4'h3, 16'd5,      16'd7,     16'd12,     1'b0},
    {4'h3, 16'hFFFF,   16'd2,     16'd1,      1'b0},
    {4'h4, 16'd9,      16'd3,     16'd6,      1'b0},
    {4'h4, 16'd3,      16'd9,     16'hFFFA,   1'b0},
    {4'h5, 16'd12,     16'd11,    16'd132,    1'b0},
    {4'h5, 16'h0100,   16'h0100,  16'd0,      1'b0},
    {4'h6, 16'd100,    16'd7,     16'd14,     1'b0},
    {4'h6, 16'd7,      16'd100,   16'd0,      1'b0},
    {4'h6, 16'd5,      16'd0,     16'hDEAD,   1'b1}
  };

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 16'h0000;
      dmem[i] = 16'h0000;
    end
  endtask

  task automatic run(output int cyc);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) check("R7 run timeout", 32'd0, 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    wipe();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 error", {31'd0, error}, 32'd0);
    check("R1 we", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle done", {31'd0, done}, 32'd0);
    check("R1 idle we", {31'd0, dmem_we}, 32'd0);

    // table walk: R5 / R6
    for (int i = 0; i < 9; i++) begin
      logic [3:0]  op;
      logic [15:0] a, b, e;
      logic        ee;
      {op, a, b, e, ee} = VEC[i];
      wipe();
      dmem[10] = a; dmem[11] = b; dmem[20] = 16'hDEAD;
      imem[0] = ins(4'h1, 12'd10);
      imem[1] = ins(4'h1, 12'd11);
      imem[2] = ins(op, 12'hABC);
      imem[3] = ins(4'h2, 12'd20);
      imem[4] = ins(4'h0, 12'd0);
      run(cyc);
      check(op == 4'h6 ? "R6 result" : "R5 result", {16'd0, dmem[20]}, {16'd0, e});
      check(op == 4'h6 ? "R6 error" : "R5 error", {31'd0, error}, {31'd0, ee});
      if (i == 0) check("R2 cycles", cyc, 32'd5);
    end

    // R3 R4 R5: (3+4)*(10*(2+6)+8) with intermediates stored
    wipe();
    dmem[0] = 16'd3; dmem[1] = 16'd4; dmem[2] = 16'd10;
    dmem[3] = 16'd2; dmem[4] = 16'd6; dmem[5] = 16'd8;
    imem[0]  = ins(4'h1, 12'd0);
    imem[1]  = ins(4'h1, 12'd1);
    imem[2]  = ins(4'h3, 12'd0);
    imem[3]  = ins(4'h2, 12'd30);
    imem[4]  = ins(4'h1, 12'd30);
    imem[5]  = ins(4'h1, 12'd2);
    imem[6]  = ins(4'h1, 12'd3);
    imem[7]  = ins(4'h1, 12'd4);
    imem[8]  = ins(4'h3, 12'd0);
    imem[9]  = ins(4'h5, 12'd0);
    imem[10] = ins(4'h2, 12'd31);
    imem[11] = ins(4'h1, 12'd31);
    imem[12] = ins(4'h1, 12'd5);
    imem[13] = ins(4'h3, 12'd0);
    imem[14] = ins(4'h2, 12'd32);
    imem[15] = ins(4'h1, 12'd32);
    imem[16] = ins(4'h5, 12'd0);
    imem[17] = ins(4'h2, 12'd40);
    run(cyc);
    check("R5 first sum", {16'd0, dmem[30]}, 32'd7);
    check("R5 product", {16'd0, dmem[31]}, 32'd80);
    check("R5 inner sum", {16'd0, dmem[32]}, 32'd88);
    check("R3 final", {16'd0, dmem[40]}, 32'd616);
    check("R7 no error", {31'd0, error}, 32'd0);
    check("R2 cycles long", cyc, 32'd19);

    // R4: A+(B*C)+D leaves sources untouched
    wipe();
    dmem[0] = 16'd5; dmem[1] = 16'd6; dmem[2] = 16'd7; dmem[3] = 16'd9;
    imem[0] = ins(4'h1, 12'd0);
    imem[1] = ins(4'h1, 12'd1);
    imem[2] = ins(4'h1, 12'd2);
    imem[3] = ins(4'h5, 12'd0);
    imem[4] = ins(4'h3, 12'd0);
    imem[5] = ins(4'h1, 12'd3);
    imem[6] = ins(4'h3, 12'd0);
    imem[7] = ins(4'h2, 12'd8);
    run(cyc);
    check("R4 result", {16'd0, dmem[8]}, 32'd56);
    check("R4 src", {dmem[0], dmem[1]}, {16'd5, 16'd6});
    check("R4 src", {dmem[2], dmem[3]}, {16'd7, 16'd9});

    // R8: exactly 8 entries fit
    wipe();
    for (int k = 0; k < 9; k++) dmem[k] = 16'(k + 100);
    for (int k = 0; k < 8; k++) imem[k] = ins(4'h1, 12'(k));
    imem[8] = ins(4'h2, 12'd50);
    run(cyc);
    check("R8 eight ok", {31'd0, error}, 32'd0);
    check("R8 eight top", {16'd0, dmem[50]}, 32'd107);
    // R8 / R11: ninth load faults, later store skipped
    dmem[50] = 16'hBEEF;
    for (int k = 0; k < 9; k++) imem[k] = ins(4'h1, 12'(k));
    imem[9] = ins(4'h2, 12'd50);
    run(cyc);
    check("R8 overflow", {30'd0, done, error}, 32'd3);
    check("R11 no store", {16'd0, dmem[50]}, 32'hBEEF);

    // R2: restart clears a stale stack; first store must fault (R9)
    wipe();
    dmem[1] = 16'd1;
    imem[0] = ins(4'h1, 12'd1);
    imem[1] = ins(4'h1, 12'd1);
    run(cyc);
    check("R2 clean run", {30'd0, done, error}, 32'd2);
    imem[0] = ins(4'h2, 12'd50);
    dmem[50] = 16'h1234;
    run(cyc);
    check("R2 stack emptied", {30'd0, done, error}, 32'd3);
    check("R9 no write", {16'd0, dmem[50]}, 32'h1234);

    // R9: operator with one entry
    wipe();
    dmem[0] = 16'd4;
    imem[0] = ins(4'h1, 12'd0);
    imem[1] = ins(4'h3, 12'd0);
    imem[2] = ins(4'h2, 12'd50);
    run(cyc);
    check("R9 short operand", {30'd0, done, error}, 32'd3);
    check("R9 short no write", {16'd0, dmem[50]}, 32'd0);

    // R10: illegal opcode
    wipe();
    imem[0] = ins(4'h9, 12'd0);
    run(cyc);
    check("R10 illegal", {30'd0, done, error}, 32'd3);
    check("R10 cycles", cyc, 32'd1);

    // R7: halt stops execution and holds done
    wipe();
    dmem[0] = 16'd77; dmem[50] = 16'h5555;
    imem[0] = ins(4'h1, 12'd0);
    imem[1] = ins(4'h0, 12'hFFF);
    imem[2] = ins(4'h2, 12'd50);
    run(cyc);
    repeat (5) @(negedge clk);
    check("R7 done held", {30'd0, done, error}, 32'd2);
    check("R7 halted", {16'd0, dmem[50]}, 32'h5555);
    check("R11 quiet", {31'd0, dmem_we}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule